// File: doc/BRIEF.md
# Transmit Retry Controller with Backoff and Status Word

This block decides what a transmitter on a shared, collision-prone medium does after each attempt. A host pulse starts a packet. While the frame serializer drives the line, the block watches collision, carrier sense, FIFO underrun and transmit-enable. After each collision it increments a collision count. It then waits a random number of slot times and raises a one-cycle retry strobe, which tells the serializer to send the frame again. When the sixteenth attempt also collides, the block gives up.

After a frame ends without a collision, the block opens a short window in the interframe gap. It looks for the transceiver's collision-detect heartbeat in that window. It then signals completion. Throughout the packet it gathers an 8-bit status word recording what happened on the medium. The random delay comes from a free-running LFSR. A priority option called offset mode stretches the delay range for the first three collisions, so a node using it backs off longer on average.

Top module: `csma_retry_ctrl`

## Requirements
- R1: After reset, and in the cycle after a start pulse accepted while idle, `status_o` reads 0x00 and `col_cnt_o` reads 0.
- R2: A collision sampled while `txen_i` is high during an attempt does three things. It increments `col_cnt_o`, it sets status bit 2 (collided), and, unless the packet aborts, it produces exactly one single-cycle `retry_o` pulse.
- R3: Without offset mode, after collision number n, `retry_o` goes high d·SLOT_CYC+1 cycles after the clock edge that sampled the collision. The draw d is an integer from 0 to 2^min(n,10)−1.
- R4: With `offset_en_i` high, for collisions 1 to 3 the range of d widens to 0..2^(n+3)−1. From collision 4 on, the range of R3 applies.
- R5: When the collision count reaches MAX_ATTEMPTS (16), the packet aborts. Status bit 3 is set, bit 0 stays clear, `col_cnt_o` reads 16, `done_o` pulses in the next cycle and no retry follows.
- R6: A collision sampled at or after transmit cycle SLOT_CYC of an attempt sets status bit 7 (late collision). The cycle count starts at 0 on the first cycle `txen_i` is high. The packet is still retried like any other collision.
- R7: Carrier sense low while `txen_i` is high, at transmit cycle PREAMBLE_CYC or later, sets status bit 4. The frame is not aborted. Carrier drops before that cycle are ignored.
- R8: Underrun during an attempt sets status bit 5 and ends the packet at once, with `done_o` in the next cycle. Bit 0 stays clear and no heartbeat window is opened.
- R9: A frame that ends without a collision or underrun sets status bit 0. If `heartbeat_i` is seen within the HB_CYC cycles after the end, bit 6 stays clear and `done_o` follows that heartbeat. If not, bit 6 is set and `done_o` follows the end of the window.
- R10: `done_o` is a single-cycle pulse, and status bit 1 always reads 0.
- R11: A start pulse that arrives while a packet is in progress has no effect. The status gathered so far is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Host pulse that begins a new packet |
| txen_i | input | 1 | High while the serializer drives a frame |
| col_i | input | 1 | Collision detected on the medium |
| crs_i | input | 1 | Carrier sense |
| underrun_i | input | 1 | Transmit FIFO ran dry |
| heartbeat_i | input | 1 | Collision-detect heartbeat from the transceiver |
| offset_en_i | input | 1 | Selects the low-priority widened backoff |
| retry_o | output | 1 | One-cycle strobe to send the frame again |
| done_o | output | 1 | One-cycle pulse when the packet is finished |
| status_o | output | 8 | Transmit status word |
| col_cnt_o | output | CNT_W | Collisions in the current packet |

## Verification
The backoff is checked with packets that carry zero to four collisions and with a run of sixteen. Each of these is tried with offset mode both off and on, and each measured gap is checked against the range allowed for that collision number. Collisions placed before and after one slot time show whether the late-collision bit follows the cycle count. Carrier drops placed inside and after the preamble show whether the monitoring window starts in the right cycle. Heartbeats on the last cycle of the window and just past it separate a correct window length from one that is one cycle off. An underrun frame shows that the heartbeat wait is skipped, and a start pulse during the gap shows that a busy packet is not cleared.

// File: rtl/csma_retry_pkg.sv
package csma_retry_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_XMIT,
      ST_WAIT,
      ST_GAP
   } txr_state_e;

   // status word bit positions
   localparam int unsigned SB_PTX = 0;
   localparam int unsigned SB_COL = 2;
   localparam int unsigned SB_ABT = 3;
   localparam int unsigned SB_CRS = 4;
   localparam int unsigned SB_FU  = 5;
   localparam int unsigned SB_CDH = 6;
   localparam int unsigned SB_OWC = 7;

   typedef struct packed {
      logic owc;
      logic cdh;
      logic fu;
      logic crs;
      logic abt;
      logic col;
      logic ptx;
   } txr_evt_t;

   // exponent of the backoff range after collision n
   function automatic int unsigned bo_exp(input int unsigned n, input logic ofs,
                                          input int unsigned cap);
      int unsigned e;
      e = (ofs && n <= 3) ? n + 3 : n;
      return (e > cap) ? cap : e;
   endfunction

endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
   parameter int unsigned W     = 16,
   parameter int unsigned OUT_W = 10,
   parameter logic [W-1:0] SEED = W'(16'hACE1)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd_o
);
   logic [W-1:0] taps;
   logic [W-1:0] st;

   generate
      if (W == 8) begin : g_w8
         assign taps = W'(8'hB8);
      end else if (W == 16) begin : g_w16
         assign taps = W'(16'hB400);
      end else if (W == 32) begin : g_w32
         assign taps = W'(32'h8020_0003);
      end else begin : g_bad
         $error("csma_lfsr: width must be 8, 16 or 32");
      end
      if (OUT_W > W) begin : g_bad_out
         $error("csma_lfsr: OUT_W exceeds W");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("csma_lfsr: seed must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= SEED;
      else        st <= {1'b0, st[W-1:1]} ^ (st[0] ? taps : '0);
   end

   assign rnd_o = st[OUT_W-1:0];

   // R3: generator must never lock up in the all-zero state
   p_lfsr_alive_r3: assert property (@(posedge clk) disable iff (!rst_n) st != '0);

endmodule

// File: rtl/csma_backoff.sv
module csma_backoff
   import csma_retry_pkg::*;
#(
   parameter int unsigned SLOT_CYC = 5120,
   parameter int unsigned CAP      = 10,
   parameter int unsigned CNT_W    = 5,
   localparam int unsigned SC_W    = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] ncol_i,
   input  logic             offset_i,
   input  logic [CAP-1:0]   rnd_i,
   output logic             due_o
);
   logic           busy;
   logic [CAP-1:0] slots;
   logic [CAP-1:0] mask_d;
   logic [CAP-1:0] mask_q;
   logic [SC_W-1:0] cyc;
   int unsigned    exp_d;

   always_comb begin
      exp_d = bo_exp(int'(ncol_i), offset_i, CAP);
      for (int b = 0; b < CAP; b++) mask_d[b] = (b < exp_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         slots  <= '0;
         mask_q <= '0;
         cyc    <= '0;
      end else if (load_i) begin
         busy   <= 1'b1;
         slots  <= rnd_i & mask_d;
         mask_q <= mask_d;
         cyc    <= '0;
      end else if (busy) begin
         if (slots == '0) begin
            busy <= 1'b0;
         end else if (cyc == SC_W'(SLOT_CYC - 1)) begin
            cyc   <= '0;
            slots <= slots - 1'b1;
         end else begin
            cyc <= cyc + 1'b1;
         end
      end
   end

   assign due_o = busy && (slots == '0);

   // R3, R4: the remaining slot count never leaves the drawn range
   p_slots_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((slots & ~mask_q) == '0));

endmodule

// File: rtl/csma_txstat.sv
module csma_txstat
   import csma_retry_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr_i,
   input  txr_evt_t evt_i,
   output logic [7:0] status_o
);
   logic [7:0] stat;
   logic [7:0] set_v;

   always_comb begin
      set_v         = '0;
      set_v[SB_PTX] = evt_i.ptx;
      set_v[SB_COL] = evt_i.col;
      set_v[SB_ABT] = evt_i.abt;
      set_v[SB_CRS] = evt_i.crs;
      set_v[SB_FU]  = evt_i.fu;
      set_v[SB_CDH] = evt_i.cdh;
      set_v[SB_OWC] = evt_i.owc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stat <= '0;
      else if (clr_i) stat <= '0;
      else            stat <= stat | set_v;
   end

   assign status_o = stat;

   // R5, R8: a good-transmit flag never coexists with abort or underrun
   p_ptx_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat[SB_PTX] |-> !(stat[SB_ABT] || stat[SB_FU]));

endmodule

// File: rtl/csma_retry_ctrl.sv
module csma_retry_ctrl
   import csma_retry_pkg::*;
#(
   parameter int unsigned MAX_ATTEMPTS = 16,
   parameter int unsigned SLOT_CYC     = 5120,
   parameter int unsigned PREAMBLE_CYC = 640,
   parameter int unsigned HB_CYC       = 640,
   parameter int unsigned BO_CAP       = 10,
   parameter int unsigned LFSR_W       = 16,
   parameter logic [LFSR_W-1:0] LFSR_SEED = LFSR_W'(16'hACE1),
   localparam int unsigned CNT_W  = $clog2(MAX_ATTEMPTS + 1),
   localparam int unsigned TC_MAX = (SLOT_CYC > PREAMBLE_CYC) ? SLOT_CYC : PREAMBLE_CYC,
   localparam int unsigned TC_W   = $clog2(TC_MAX + 1),
   localparam int unsigned HB_W   = $clog2(HB_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             txen_i,
   input  logic             col_i,
   input  logic             crs_i,
   input  logic             underrun_i,
   input  logic             heartbeat_i,
   input  logic             offset_en_i,
   output logic             retry_o,
   output logic             done_o,
   output logic [7:0]       status_o,
   output logic [CNT_W-1:0] col_cnt_o
);

   generate
      if (MAX_ATTEMPTS < 2)     begin : g_bad_att  $error("MAX_ATTEMPTS below 2"); end
      if (SLOT_CYC < 1)         begin : g_bad_slot $error("SLOT_CYC below 1"); end
      if (HB_CYC < 1)           begin : g_bad_hb   $error("HB_CYC below 1"); end
      if (BO_CAP > 16 || BO_CAP < 1) begin : g_bad_cap $error("BO_CAP out of range"); end
      if (BO_CAP > LFSR_W)      begin : g_bad_rw   $error("BO_CAP exceeds LFSR_W"); end
   endgenerate

   txr_state_e       state;
   logic [TC_W-1:0]  txcyc;
   logic             tx_seen;
   logic [HB_W-1:0]  gcnt;
   logic [CNT_W-1:0] col_cnt;
   logic             retry_q;
   logic             done_q;

   logic [BO_CAP-1:0] rnd;
   logic              due;
   txr_evt_t          evt;

   logic             in_x, start_ok, col_ev, ur_ev, end_ev, abort_ev, crs_ev;
   logic             hb_ok, hb_miss, bo_load;
   logic [CNT_W-1:0] ncol_next;

   always_comb begin
      in_x      = (state == ST_XMIT);
      start_ok  = (state == ST_IDLE) && start_i;
      ur_ev     = in_x && underrun_i;
      col_ev    = in_x && txen_i && col_i && !underrun_i;
      end_ev    = in_x && tx_seen && !txen_i && !underrun_i;
      ncol_next = col_cnt + 1'b1;
      abort_ev  = col_ev && (ncol_next == CNT_W'(MAX_ATTEMPTS));
      crs_ev    = in_x && txen_i && !crs_i && (txcyc >= TC_W'(PREAMBLE_CYC));
      hb_ok     = (state == ST_GAP) && heartbeat_i;
      hb_miss   = (state == ST_GAP) && !heartbeat_i && (gcnt == HB_W'(HB_CYC - 1));
      bo_load   = col_ev && !abort_ev;

      evt.ptx = end_ev;
      evt.col = col_ev;
      evt.abt = abort_ev;
      evt.crs = crs_ev;
      evt.fu  = ur_ev;
      evt.cdh = hb_miss;
      evt.owc = col_ev && (txcyc >= TC_W'(SLOT_CYC));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         txcyc   <= '0;
         tx_seen <= 1'b0;
         gcnt    <= '0;
         col_cnt <= '0;
         retry_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         retry_q <= 1'b0;
         done_q  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_ok) begin
                  state   <= ST_XMIT;
                  col_cnt <= '0;
                  txcyc   <= '0;
                  tx_seen <= 1'b0;
               end
            end
            ST_XMIT: begin
               if (col_ev) col_cnt <= ncol_next;
               if (ur_ev || abort_ev) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end else if (col_ev) begin
                  state <= ST_WAIT;
               end else if (end_ev) begin
                  state <= ST_GAP;
                  gcnt  <= '0;
               end else if (txen_i) begin
                  tx_seen <= 1'b1;
                  if (txcyc != TC_W'(TC_MAX)) txcyc <= txcyc + 1'b1;
               end
            end
            ST_WAIT: begin
               if (due) begin
                  state   <= ST_XMIT;
                  retry_q <= 1'b1;
                  txcyc   <= '0;
                  tx_seen <= 1'b0;
               end
            end
            ST_GAP: begin
               if (hb_ok || hb_miss) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   csma_lfsr #(
      .W     (LFSR_W),
      .OUT_W (BO_CAP),
      .SEED  (LFSR_SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd_o (rnd)
   );

   csma_backoff #(
      .SLOT_CYC (SLOT_CYC),
      .CAP      (BO_CAP),
      .CNT_W    (CNT_W)
   ) u_backoff (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (bo_load),
      .ncol_i   (ncol_next),
      .offset_i (offset_en_i),
      .rnd_i    (rnd),
      .due_o    (due)
   );

   csma_txstat u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (start_ok),
      .evt_i    (evt),
      .status_o (status_o)
   );

   assign retry_o   = retry_q;
   assign done_o    = done_q;
   assign col_cnt_o = col_cnt;

   // R1: an accepted start leaves a cleared status and count
   p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> (status_o == 8'h00) && (col_cnt_o == '0));

   // R2: a retry is only ever issued for a packet that has collided
   p_retry_after_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
      retry_o |-> (col_cnt_o != '0) && !done_o);

   // R5: the abort flag appears together with the full attempt count
   p_abort_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_o[SB_ABT]) |-> (col_cnt_o == CNT_W'(MAX_ATTEMPTS)));

   // R10: completion is a one-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: tb/tb_csma_retry_ctrl.sv
module tb_csma_retry_ctrl;
   localparam int SLOT = 8;
   localparam int PRE  = 4;
   localparam int HB   = 6;
   localparam int MAXA = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 0, txen_i = 0, col_i = 0, crs_i = 1, underrun_i = 0;
   logic heartbeat_i = 0, offset_en_i = 0;
   logic retry_o, done_o;
   logic [7:0] status_o;
   logic [4:0] col_cnt_o;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   csma_retry_ctrl #(
      .MAX_ATTEMPTS (MAXA),
      .SLOT_CYC     (SLOT),
      .PREAMBLE_CYC (PRE),
      .HB_CYC       (HB)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .txen_i      (txen_i),
      .col_i       (col_i),
      .crs_i       (crs_i),
      .underrun_i  (underrun_i),
      .heartbeat_i (heartbeat_i),
      .offset_en_i (offset_en_i),
      .retry_o     (retry_o),
      .done_o      (done_o),
      .status_o    (status_o),
      .col_cnt_o   (col_cnt_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int range_lim(input int n, input bit ofs);
      int e;
      e = (ofs && n <= 3) ? n + 3 : n;
      if (e > 10) e = 10;
      return 1 << e;
   endfunction

   function automatic int exp_status(input bit ptx, col, abt, crs, fu, cdh, owc);
      return {24'd0, owc, cdh, fu, crs, abt, col, 1'b0, ptx};
   endfunction

   // fin_mode 0: clean end, 1: underrun at cycle 5
   task automatic run_pkt(input int ncol, input bit ofs, input int fin_mode,
                          input int crs_at, input int hb_delay, input bit busy_start,
                          input bit force_owc);
      bit e_col = 0, e_owc = 0, e_abt = 0, e_crs = 0, e_fu = 0, e_ptx = 0, e_cdh = 0;
      bit aborted = 0;
      int gap;
      offset_en_i = ofs;
      @(negedge clk) start_i = 1;
      @(negedge clk) start_i = 0;
      check(status_o == 8'h00 && col_cnt_o == 0, "R1 start clears", status_o, 0);
      for (int c = 1; c <= ncol && !aborted; c++) begin
         int len;
         int at;
         bit ow;
         len = 12 + $urandom_range(0, 8);
         ow  = force_owc || ($urandom_range(0, 3) == 0);
         at  = ow ? $urandom_range(SLOT, len - 1) : $urandom_range(0, SLOT - 1);
         repeat (2) @(negedge clk);
         for (int i = 0; i <= at; i++) begin
            @(negedge clk);
            txen_i = 1;
            col_i  = (i == at);
         end
         @(negedge clk);
         txen_i = 0;
         col_i  = 0;
         e_col = 1;
         if (ow) e_owc = 1;
         check(col_cnt_o == c, "R2 collision count", col_cnt_o, c);
         if (c == MAXA) begin
            aborted = 1;
            e_abt = 1;
            check(done_o == 1, "R5 done on abort", done_o, 1);
            check(retry_o == 0, "R5 no retry on abort", retry_o, 0);
         end else begin
            gap = 0;
            while (!retry_o && gap < 20000) begin
               @(negedge clk);
               gap++;
            end
            check(((gap - 1) % SLOT) == 0 && ((gap - 1) / SLOT) < range_lim(c, ofs),
                  ofs ? "R4 offset backoff range" : "R3 backoff range", gap - 1,
                  (range_lim(c, ofs) - 1) * SLOT);
            @(negedge clk);
            check(retry_o == 0, "R2 retry single pulse", retry_o, 0);
         end
      end
      if (aborted) begin
         @(negedge clk);
         check(done_o == 0, "R10 done one cycle", done_o, 0);
         check(status_o == exp_status(0, e_col, 1, 0, 0, 0, e_owc),
               "R5 abort status", status_o, exp_status(0, e_col, 1, 0, 0, 0, e_owc));
         check(col_cnt_o == MAXA, "R5 final count", col_cnt_o, MAXA);
         return;
      end
      repeat (2) @(negedge clk);
      if (fin_mode == 1) begin
         for (int i = 0; i <= 5; i++) begin
            @(negedge clk);
            txen_i = 1;
            underrun_i = (i == 5);
         end
         @(negedge clk);
         txen_i = 0;
         underrun_i = 0;
         e_fu = 1;
         check(done_o == 1, "R8 done right after underrun", done_o, 1);
      end else begin
         for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            txen_i = 1;
            crs_i  = !(i == crs_at);
         end
         @(negedge clk);
         txen_i = 0;
         crs_i  = 1;
         e_ptx = 1;
         if (crs_at >= PRE && crs_at < 14) e_crs = 1;
         e_cdh = (hb_delay >= HB);
         @(negedge clk);
         for (int j = 0; j < HB + 12; j++) begin
            heartbeat_i = (j == hb_delay);
            start_i = busy_start && (j == 0);
            @(negedge clk);
            heartbeat_i = 0;
            start_i = 0;
            if (done_o) begin
               check(j == (e_cdh ? HB - 1 : hb_delay), "R9 done timing", j,
                     e_cdh ? HB - 1 : hb_delay);
               break;
            end
            if (j == HB + 11) check(0, "R9 done never seen", 0, 1);
         end
      end
      check(status_o == exp_status(e_ptx, e_col, e_abt, e_crs, e_fu, e_cdh, e_owc),
            busy_start ? "R11 busy start ignored" : "R6 R7 R8 R9 R10 status word",
            status_o, exp_status(e_ptx, e_col, e_abt, e_crs, e_fu, e_cdh, e_owc));
      @(negedge clk);
      check(done_o == 0, "R10 done one cycle", done_o, 0);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(status_o == 8'h00 && col_cnt_o == 0 && !done_o && !retry_o,
            "R1 reset state", status_o, 0);
      run_pkt(0, 0, 0, -1, 2, 0, 0);        // R9 heartbeat seen
      run_pkt(0, 0, 0, -1, HB + 3, 0, 0);   // R9 heartbeat missing
      run_pkt(0, 0, 0, -1, HB - 1, 0, 0);   // R9 last cycle of window
      run_pkt(0, 0, 0, -1, HB, 0, 0);       // R9 one past the window
      run_pkt(0, 0, 0, PRE + 2, 1, 0, 0);   // R7 carrier lost
      run_pkt(0, 0, 0, PRE - 2, 1, 0, 0);   // R7 drop inside preamble ignored
      run_pkt(0, 0, 1, -1, 0, 0, 0);        // R8 underrun
      run_pkt(3, 0, 0, -1, 1, 0, 0);        // R3
      run_pkt(1, 0, 0, -1, 1, 0, 1);        // R6 late collision
      run_pkt(4, 1, 0, -1, 1, 0, 0);        // R4
      run_pkt(2, 0, 0, -1, HB + 2, 1, 0);   // R11
      for (int k = 0; k < 6; k++) begin
         run_pkt($urandom_range(0, 4), $urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom_range(0, 20) - 4, $urandom_range(0, HB + 2), 0, 0);
      end
      run_pkt(MAXA, 1, 0, -1, 1, 0, 0);     // R5 abort
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule